// File: doc/BRIEF.md
# Transmit Bit Error Monitor

This block sits next to a UART transmitter whose bit period is divided into sixteen oversampling ticks. While the transmitter is busy, the block reads the receive line once per transmitted bit, at one tick chosen by a two-bit mode field. It compares that level with the bit being driven. A mismatch means another driver is fighting for the line. On a mismatch the block sets a sticky error flag. The flag is gated by an interrupt enable to form an interrupt request. Start, data, parity and stop bits are all checked in the same way.

The mode field and a break-detect enable live in a small control register. That register is reachable through a simple register port, but only while an alternate map select input is high. The break-detect enable is only stored and passed on to a neighbouring block. Software clears the error flag by writing a one to bit 0 of a separate status write port.

The transmitter supplies the tick count as a value from 0 to 15, together with a one-cycle tick strobe. Count value 0 is the first tick of the bit, so the 9th tick is count 8 and the 13th tick is count 12.

Top module: `txbe_monitor`

## Requirements
- R1: After reset, the control register reads 0x00 while map select is high, the error flag is 0, the interrupt request is 0 and the break enable output is 0.
- R2: With mode code 01, the receive line is compared with the transmitted bit only in a cycle where the tick strobe is high and the tick count is 8 (the 9th tick). A mismatch there sets the error flag on the next clock edge.
- R3: With mode code 10, the comparison happens only in a cycle where the tick strobe is high and the tick count is 12 (the 13th tick). A mismatch there sets the error flag on the next clock edge.
- R4: With mode code 00 or 11, a mismatch never sets the error flag.
- R5: No comparison takes place while the busy input is low or the tick strobe is low, whatever the tick count and line levels are.
- R6: The error flag stays set until a status write with data bit 0 equal to 1 clears it. A status write with bit 0 equal to 0 leaves the flag unchanged. When a new mismatch and a clear arrive in the same cycle, the flag is set.
- R7: The interrupt request equals the error flag ANDed with the interrupt enable input, with no added delay.
- R8: Control read data holds the mode field in bits 2:1 and the break enable in bit 0. Bits 7:3 always read 0. The whole read value is 0x00 while map select is low.
- R9: A control write while map select is low changes neither the mode nor the break enable.
- R10: The break enable output follows control bit 0 from the clock edge of an accepted write onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| map_sel | input | 1 | Alternate map select; control access is allowed only while this is high |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read data |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 8 | Status write data; bit 0 = 1 clears the error flag |
| tx_busy | input | 1 | The transmitter is shifting a frame |
| tx_bit | input | 1 | Level currently being driven on the transmit line |
| tick_cnt | input | 4 | Tick index within the current bit, 0 to 15 |
| tick_stb | input | 1 | High for one cycle when tick_cnt takes a new value |
| rxd | input | 1 | Receive line level |
| err_ie | input | 1 | Interrupt enable for the bit error flag |
| err_flag | output | 1 | Sticky bit error flag |
| err_irq | output | 1 | Interrupt request |
| brk_en | output | 1 | Break detect enable passed to the neighbouring block |

## Verification
The bench builds the block with its default parameters: sixteen ticks per bit, sample points at ticks 9 and 13, and an 8-bit control register. With these values, every one of the sixteen tick counts is driven in every bit of every frame. Each frame corrupts the receive line in only one tick window, so the bench can show that the selected tick is the only one that counts. Between ticks the strobe is held low while the count and the corrupted level stay put, which shows that each bit is compared once and not once per clock.

// File: rtl/txbe_pkg.sv
package txbe_pkg;

   // Two-bit mode codes that choose the sampling tick.
   typedef enum logic [1:0] {
      MODE_OFF   = 2'b00,
      MODE_EARLY = 2'b01,
      MODE_LATE  = 2'b10,
      MODE_RSVD  = 2'b11
   } txbe_mode_e;

   // Bit positions inside the control register.
   localparam int CTL_BRK_BIT  = 0;
   localparam int CTL_MODE_LSB = 1;
   localparam int CTL_USED     = 3;

   typedef struct packed {
      txbe_mode_e mode;
      logic       brk_en;
   } txbe_ctl_t;

endpackage

// File: rtl/txbe_ctrl_reg.sv
module txbe_ctrl_reg
   import txbe_pkg::*;
#(
   parameter int REG_W = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             map_sel,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   output txbe_ctl_t        ctl
);

   localparam int PAD_W = REG_W - CTL_USED;

   generate
      if (REG_W < CTL_USED) begin : g_bad_width
         $error("txbe_ctrl_reg: REG_W must be at least %0d", CTL_USED);
      end
   endgenerate

   txbe_ctl_t ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '{mode: MODE_OFF, brk_en: 1'b0};
      end else if (map_sel && wr_en) begin
         ctl_q.mode   <= txbe_mode_e'(wr_data[CTL_MODE_LSB +: 2]);
         ctl_q.brk_en <= wr_data[CTL_BRK_BIT];
      end
   end

   assign ctl = ctl_q;

   // Read path: the unused upper bits are padded with zeros.
   logic [CTL_USED-1:0] used_bits;
   always_comb begin
      used_bits = '0;
      used_bits[CTL_BRK_BIT]           = ctl_q.brk_en;
      used_bits[CTL_MODE_LSB +: 2]     = ctl_q.mode;
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign rd_data = map_sel ? {{PAD_W{1'b0}}, used_bits} : '0;
      end else begin : g_nopad
         assign rd_data = map_sel ? used_bits : '0;
      end
   endgenerate

   // R9: the register holds its value while the map is not selected
   a_r9_locked_without_map : assert property (@(posedge clk) disable iff (!rst_n)
      !map_sel |=> $stable(ctl_q));

endmodule

// File: rtl/txbe_sample_point.sv
module txbe_sample_point
   import txbe_pkg::*;
#(
   parameter int OVERSAMPLE = 16,
   parameter int EARLY_TICK = 9,
   parameter int LATE_TICK  = 13,
   parameter int TICK_W     = $clog2(OVERSAMPLE)
)(
   input  txbe_mode_e        mode,
   input  logic              tx_busy,
   input  logic              tick_stb,
   input  logic [TICK_W-1:0] tick_cnt,
   output logic              sample_now
);

   // Ticks are numbered from 1, while the count starts at 0.
   localparam logic [TICK_W-1:0] EARLY_IDX = TICK_W'(EARLY_TICK - 1);
   localparam logic [TICK_W-1:0] LATE_IDX  = TICK_W'(LATE_TICK - 1);

   generate
      if (EARLY_TICK < 1 || EARLY_TICK > OVERSAMPLE) begin : g_bad_early
         $error("txbe_sample_point: EARLY_TICK outside 1..OVERSAMPLE");
      end
      if (LATE_TICK < 1 || LATE_TICK > OVERSAMPLE) begin : g_bad_late
         $error("txbe_sample_point: LATE_TICK outside 1..OVERSAMPLE");
      end
      if ((1 << TICK_W) < OVERSAMPLE) begin : g_bad_tick_w
         $error("txbe_sample_point: TICK_W too narrow");
      end
   endgenerate

   logic at_point;
   always_comb begin
      unique case (mode)
         MODE_EARLY: at_point = (tick_cnt == EARLY_IDX);
         MODE_LATE:  at_point = (tick_cnt == LATE_IDX);
         default:    at_point = 1'b0;
      endcase
   end

   assign sample_now = tx_busy && tick_stb && at_point;

endmodule

// File: rtl/txbe_err_flag.sv
module txbe_err_flag #(
   parameter int REG_W   = 8,
   parameter int CLR_BIT = 0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sample_now,
   input  logic             tx_bit,
   input  logic             rxd,
   input  logic             clr_wr,
   input  logic [REG_W-1:0] clr_data,
   input  logic             irq_en,
   output logic             flag,
   output logic             irq
);

   generate
      if (CLR_BIT < 0 || CLR_BIT >= REG_W) begin : g_bad_clr
         $error("txbe_err_flag: CLR_BIT outside the status word");
      end
   endgenerate

   logic mismatch, clear_req, flag_q;

   assign mismatch  = sample_now && (rxd != tx_bit);
   assign clear_req = clr_wr && clr_data[CLR_BIT];

   // A new error takes priority over a clear in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flag_q <= 1'b0;
      else if (mismatch)  flag_q <= 1'b1;
      else if (clear_req) flag_q <= 1'b0;
   end

   assign flag = flag_q;
   assign irq  = flag_q && irq_en;

   // R6: once set, the flag survives until a clear request arrives
   a_r6_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clear_req) |=> flag_q);

   // R6: a simultaneous error and clear leaves the flag set
   a_r6_set_wins : assert property (@(posedge clk) disable iff (!rst_n)
      (sample_now && (rxd != tx_bit) && clear_req) |=> flag_q);

endmodule

// File: rtl/txbe_monitor.sv
module txbe_monitor
   import txbe_pkg::*;
#(
   parameter int OVERSAMPLE = 16,
   parameter int EARLY_TICK = 9,
   parameter int LATE_TICK  = 13,
   parameter int REG_W      = 8,
   localparam int TICK_W    = $clog2(OVERSAMPLE)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              map_sel,
   input  logic              ctl_wr,
   input  logic [REG_W-1:0]  ctl_wdata,
   output logic [REG_W-1:0]  ctl_rdata,
   input  logic              stat_wr,
   input  logic [REG_W-1:0]  stat_wdata,
   input  logic              tx_busy,
   input  logic              tx_bit,
   input  logic [TICK_W-1:0] tick_cnt,
   input  logic              tick_stb,
   input  logic              rxd,
   input  logic              err_ie,
   output logic              err_flag,
   output logic              err_irq,
   output logic              brk_en
);

   txbe_ctl_t ctl;
   logic      sample_now;

   txbe_ctrl_reg #(.REG_W(REG_W)) u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .map_sel (map_sel),
      .wr_en   (ctl_wr),
      .wr_data (ctl_wdata),
      .rd_data (ctl_rdata),
      .ctl     (ctl)
   );

   txbe_sample_point #(
      .OVERSAMPLE (OVERSAMPLE),
      .EARLY_TICK (EARLY_TICK),
      .LATE_TICK  (LATE_TICK),
      .TICK_W     (TICK_W)
   ) u_pt (
      .mode       (ctl.mode),
      .tx_busy    (tx_busy),
      .tick_stb   (tick_stb),
      .tick_cnt   (tick_cnt),
      .sample_now (sample_now)
   );

   txbe_err_flag #(.REG_W(REG_W), .CLR_BIT(0)) u_flag (
      .clk        (clk),
      .rst_n      (rst_n),
      .sample_now (sample_now),
      .tx_bit     (tx_bit),
      .rxd        (rxd),
      .clr_wr     (stat_wr),
      .clr_data   (stat_wdata),
      .irq_en     (err_ie),
      .flag       (err_flag),
      .irq        (err_irq)
   );

   assign brk_en = ctl.brk_en;

   // R4: a disabled mode never raises a clear flag
   a_r4_disabled_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      ((ctl.mode == MODE_OFF || ctl.mode == MODE_RSVD) && !err_flag) |=> !err_flag);

   // R5: an idle transmitter or a missing strobe cannot raise the flag
   a_r5_needs_busy_tick : assert property (@(posedge clk) disable iff (!rst_n)
      (!(tx_busy && tick_stb) && !err_flag) |=> !err_flag);

endmodule

// File: tb/txbe_monitor_test.sv
module txbe_monitor_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       map_sel = 1'b0, ctl_wr = 1'b0, stat_wr = 1'b0;
   logic [7:0] ctl_wdata = '0, stat_wdata = '0;
   logic       tx_busy = 1'b0, tx_bit = 1'b1, tick_stb = 1'b0, rxd = 1'b1, err_ie = 1'b0;
   logic [3:0] tick_cnt = '0;
   logic [7:0] ctl_rdata;
   logic       err_flag, err_irq, brk_en;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   // Reference model state
   logic [1:0] m_mode = 2'b00;
   logic       m_brk  = 1'b0;
   logic       m_flag = 1'b0;

   always #2.5 clk = ~clk;

   txbe_monitor uut (
      .clk(clk), .rst_n(rst_n), .map_sel(map_sel), .ctl_wr(ctl_wr),
      .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .stat_wr(stat_wr),
      .stat_wdata(stat_wdata), .tx_busy(tx_busy), .tx_bit(tx_bit),
      .tick_cnt(tick_cnt), .tick_stb(tick_stb), .rxd(rxd), .err_ie(err_ie),
      .err_flag(err_flag), .err_irq(err_irq), .brk_en(brk_en)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] exp_rd();
      return map_sel ? {5'b0, m_mode, m_brk} : 8'h00;
   endfunction

   // Compare every output against the model (inputs already driven).
   task automatic compare(input string req);
      chk({req, " flag"}, int'(err_flag), int'(m_flag));
      chk({req, " irq R7"}, int'(err_irq), int'(m_flag && err_ie));
      chk({req, " rd R8"}, int'(ctl_rdata), int'(exp_rd()));
      chk({req, " brk R10"}, int'(brk_en), int'(m_brk));
   endtask

   // One clock: inputs were set after a negedge; model the edge, then check.
   task automatic step(input string req);
      logic hit, nf;
      hit = tx_busy && tick_stb && (rxd != tx_bit) &&
            ((m_mode == 2'b01 && tick_cnt == 4'd8) || (m_mode == 2'b10 && tick_cnt == 4'd12));
      nf = m_flag;
      if (hit) nf = 1'b1;
      else if (stat_wr && stat_wdata[0]) nf = 1'b0;
      @(posedge clk);
      m_flag = nf;
      if (map_sel && ctl_wr) begin
         m_mode = ctl_wdata[2:1];
         m_brk  = ctl_wdata[0];
      end
      @(negedge clk);
      ctl_wr = 1'b0;
      stat_wr = 1'b0;
      compare(req);
   endtask

   task automatic ctl_write(input logic sel, input logic [7:0] d, input string req);
      map_sel = sel; ctl_wr = 1'b1; ctl_wdata = d;
      step(req);
      map_sel = 1'b1;
      #0 compare(req);
   endtask

   task automatic clear_flag(input logic [7:0] d, input string req);
      stat_wr = 1'b1; stat_wdata = d;
      step(req);
   endtask

   // Send one 10-bit frame; the line is forced wrong during tick bad_t of bit bad_b.
   task automatic frame(input logic [9:0] bits, input int bad_b, input int bad_t,
                        input logic busy, input string req);
      for (int b = 0; b < 10; b++) begin
         for (int t = 0; t < 16; t++) begin
            tx_busy = busy; tx_bit = bits[b]; tick_cnt = 4'(t);
            rxd = (b == bad_b && t == bad_t) ? ~bits[b] : bits[b];
            tick_stb = 1'b1;
            step(req);
            tick_stb = 1'b0;   // hold count and level: no second comparison
            step(req);
         end
      end
      tx_busy = 1'b0; tx_bit = 1'b1; rxd = 1'b1; tick_cnt = '0;
      step(req);
   endtask

   initial begin
      #12 @(negedge clk);
      rst_n = 1'b1;
      map_sel = 1'b1;
      #1;
      // R1: reset state
      chk("R1 flag", int'(err_flag), 0);
      chk("R1 irq", int'(err_irq), 0);
      chk("R1 rd", int'(ctl_rdata), 0);
      chk("R1 brk", int'(brk_en), 0);
      @(negedge clk);

      // R8 / R9: register access and map gating
      ctl_write(1'b1, 8'hFA, "R8 upper bits");          // mode 01, brk 0, 7:3 read 0
      chk("R8 readback", int'(ctl_rdata), 8'h02);
      ctl_write(1'b0, 8'hFF, "R9 locked write");
      chk("R9 unchanged", int'(ctl_rdata), 8'h02);
      map_sel = 1'b0; #1;
      chk("R8 map low reads 0", int'(ctl_rdata), 0);
      map_sel = 1'b1; #1;

      // R2: mode 01 samples tick 9 only
      err_ie = 1'b1;
      frame(10'b1_0110_1010_0, 4, 12, 1'b1, "R2 wrong tick");
      chk("R2 no error off-point", int'(err_flag), 0);
      frame(10'b1_0110_1010_0, 3, 8, 1'b1, "R2 point hit");
      chk("R2 error at tick 9", int'(err_flag), 1);
      chk("R7 irq with enable", int'(err_irq), 1);

      // R7 / R6: gating and clearing
      err_ie = 1'b0; #1;
      chk("R7 irq masked", int'(err_irq), 0);
      clear_flag(8'hFE, "R6 bit0 zero keeps");
      chk("R6 still set", int'(err_flag), 1);
      clear_flag(8'h01, "R6 clear");
      chk("R6 cleared", int'(err_flag), 0);
      err_ie = 1'b1;

      // R3: mode 10 samples tick 13 only (start and stop bits)
      ctl_write(1'b1, 8'h04, "R3 set mode");
      frame(10'b1_1100_0011_0, 0, 8, 1'b1, "R3 wrong tick");
      chk("R3 no error off-point", int'(err_flag), 0);
      frame(10'b1_1100_0011_0, 9, 12, 1'b1, "R3 stop bit hit");
      chk("R3 error at tick 13", int'(err_flag), 1);
      clear_flag(8'h01, "R6 clear");
      frame(10'b1_1100_0011_0, 0, 12, 1'b1, "R3 start bit hit");
      chk("R3 start bit error", int'(err_flag), 1);
      clear_flag(8'h01, "R6 clear");

      // R4: modes 00 and 11 disabled; R10 break enable
      ctl_write(1'b1, 8'h01, "R10 brk set");
      chk("R10 brk out", int'(brk_en), 1);
      frame(10'b1_0000_0000_0, 2, 8, 1'b1, "R4 mode00");
      frame(10'b1_1111_1111_0, 5, 12, 1'b1, "R4 mode00 late");
      ctl_write(1'b1, 8'h06, "R4 mode11");
      chk("R10 brk cleared", int'(brk_en), 0);
      frame(10'b1_0101_0101_0, 2, 8, 1'b1, "R4 mode11");
      frame(10'b1_0101_0101_0, 6, 12, 1'b1, "R4 mode11 late");
      chk("R4 no error", int'(err_flag), 0);

      // R5: idle transmitter never compared
      ctl_write(1'b1, 8'h02, "R5 set mode");
      frame(10'b1_1010_0101_0, 1, 8, 1'b0, "R5 idle");
      chk("R5 no error idle", int'(err_flag), 0);

      // R6: error and clear in the same cycle -> set
      tx_busy = 1'b1; tx_bit = 1'b0; rxd = 1'b1; tick_cnt = 4'd8; tick_stb = 1'b1;
      stat_wr = 1'b1; stat_wdata = 8'h01;
      step("R6 set wins");
      chk("R6 set beats clear", int'(err_flag), 1);
      tx_busy = 1'b0; tick_stb = 1'b0; rxd = 1'b0;
      step("R6 hold");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule